// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block decides, every clock, how much of a fetched two-instruction packet may enter execution. The packet is 64 bits wide. The left half carries an instruction bound for the integer side, which covers ALU operations, branches, loads and stores. The right half carries a floating-point operation. The block receives each half already decoded into a valid bit, a class code and register tags. It answers with one issue flag per half, a hold request back to fetch, and a slide flag. The slide flag tells fetch that the right instruction did not go and must be presented as the next left instruction.

Loads return their value one cycle late. The block keeps the destination tag of a load that issued in the previous cycle in a two-state shadow machine, and it holds any instruction that reads that tag. The machine has two states. SHD_EMPTY means no load result is in flight. SHD_ARMED means a load issued on the previous edge and its tag is live. There are four transitions:
- reset goes to SHD_EMPTY;
- SHD_EMPTY goes to SHD_ARMED when a load with a destination issues;
- SHD_ARMED stays in SHD_ARMED when another such load issues;
- SHD_ARMED returns to SHD_EMPTY on any cycle without one.

The per-cycle outcome is a combinational decision with five values:
- DEC_RESET while reset is applied;
- DEC_EMPTY when the left slot is empty;
- DEC_HOLD when the left instruction waits on the load;
- DEC_SINGLE when only the left instruction goes;
- DEC_PAIR when both go.

Top module: `pair_issue_ctl`

## Requirements
- R1: While rst_n is low, issue_l, issue_r, fetch_hold and slide_r are all 0. Reset also empties the load shadow, so a consumer presented right after reset is not held.
- R2: A register tag is {file bit, index}: bit 5 set names the FP file and clear names the integer file. A valid left instruction is held (fetch_hold=1, issue_l=0) exactly when one of its enabled sources equals the full tag of a load that issued with write enable on the previous edge. The same index in the other file does not match.
- R3: issue_r is never 1 unless issue_l is 1 in the same cycle. A valid right instruction beside an empty left slot does not issue.
- R4: Class codes are 0 ALU, 1 branch, 2 load, 3 store and 4 FP operation; 5 to 7 are other. Both slots issue only if the left class is 0 to 3 and the right class is 4. Otherwise the left instruction issues alone.
- R5: If an enabled source of the right instruction equals the left destination tag and the left write enable is 1, only the left instruction issues. A left destination with write enable 0 never blocks the pair.
- R6: A right instruction with an enabled source equal to the previous cycle's load tag does not issue, while the left instruction may.
- R7: The load delay lasts one cycle. An instruction two pairs after the load that reads the load's tag issues normally.
- R8: An FP load on the left and an independent FP operation on the right issue together.
- R9: During a hold, issue_l, issue_r and slide_r are 0. The same pair presented on the next cycle is no longer blocked by that load.
- R10: slide_r is 1 exactly when the right slot is valid, did not issue, and fetch_hold is 0.
- R11: Only a load that issues with write enable 1 arms the shadow. A held load, or a load with write enable 0, does not delay the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_valid | input | 1 | Left slot holds an instruction |
| l_cls | input | 3 | Left class code |
| l_dst | input | 6 | Left destination tag |
| l_dst_we | input | 1 | Left instruction writes l_dst |
| l_src1 | input | 6 | Left first source tag |
| l_src1_en | input | 1 | Left first source is read |
| l_src2 | input | 6 | Left second source tag |
| l_src2_en | input | 1 | Left second source is read |
| r_valid | input | 1 | Right slot holds an instruction |
| r_cls | input | 3 | Right class code |
| r_src1 | input | 6 | Right first source tag |
| r_src1_en | input | 1 | Right first source is read |
| r_src2 | input | 6 | Right second source tag |
| r_src2_en | input | 1 | Right second source is read |
| issue_l | output | 1 | Left instruction issues this cycle |
| issue_r | output | 1 | Right instruction issues this cycle |
| fetch_hold | output | 1 | Keep the current pair unchanged |
| slide_r | output | 1 | Present the unissued right instruction as next left |

## Verification
The bench presents a load followed by consumers in each position: the right half of the same pair, the left and right halves of the next pair, and a pair two cycles later. A design with the wrong delay length either issues a stale read or keeps stalling after the value is ready. Tag matching is probed with the same index in the opposite file and with disabled source or destination enables. A design that ignores the file bit or an enable holds or splits a pair that should go together. A held load, a load without a destination, an empty left slot beside a valid FP operation, and a reset that arrives while the shadow is armed are each driven. A design that arms on an unissued load, lets the right half go alone, or keeps the shadow across reset shows a wrong issue or hold flag.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

    // Instruction class codes carried in the 3-bit class field
    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_FPOP   = 3'd4
    } op_class_e;

    // What a slot's class means to the pairing logic
    typedef enum logic [1:0] {
        ROLE_INT,
        ROLE_LOAD,
        ROLE_FP,
        ROLE_OTHER
    } slot_role_e;

    // Load shadow machine
    typedef enum logic {
        SHD_EMPTY,
        SHD_ARMED
    } shadow_state_e;

    // Per-cycle issue outcome
    typedef enum logic [2:0] {
        DEC_RESET,
        DEC_EMPTY,
        DEC_HOLD,
        DEC_SINGLE,
        DEC_PAIR
    } issue_dec_e;

    localparam int NUM_SLOTS  = 2;
    localparam int SLOT_LEFT  = 0;
    localparam int SLOT_RIGHT = 1;

endpackage

// File: rtl/slot_decode.sv
module slot_decode
    import pair_issue_pkg::*;
(
    input  logic [2:0] cls_i,
    output slot_role_e role_o
);

    always_comb begin
        unique case (op_class_e'(cls_i))
            CLS_ALU, CLS_BRANCH, CLS_STORE: role_o = ROLE_INT;
            CLS_LOAD:                       role_o = ROLE_LOAD;
            CLS_FPOP:                       role_o = ROLE_FP;
            default:                        role_o = ROLE_OTHER;
        endcase
    end

endmodule

// File: rtl/src_match.sv
module src_match #(
    parameter int TAG_W = 6
) (
    input  logic [TAG_W-1:0] src_a_i,
    input  logic             src_a_en_i,
    input  logic [TAG_W-1:0] src_b_i,
    input  logic             src_b_en_i,
    input  logic [TAG_W-1:0] prod_tag_i,
    input  logic             prod_en_i,
    output logic             hit_o
);

    logic a_hit;
    logic b_hit;

    always_comb begin
        a_hit = src_a_en_i && (src_a_i == prod_tag_i);
        b_hit = src_b_en_i && (src_b_i == prod_tag_i);
        hit_o = prod_en_i && (a_hit || b_hit);
    end

endmodule

// File: rtl/load_shadow_fsm.sv
module load_shadow_fsm
    import pair_issue_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             armed_o,
    output logic [TAG_W-1:0] tag_o
);

    shadow_state_e    state_q;
    shadow_state_e    state_d;
    logic [TAG_W-1:0] tag_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SHD_EMPTY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (capture_i) begin
                tag_q <= tag_i;
            end
        end
    end

    // Transitions
    always_comb begin
        unique case (state_q)
            SHD_EMPTY: state_d = capture_i ? SHD_ARMED : SHD_EMPTY;
            SHD_ARMED: state_d = capture_i ? SHD_ARMED : SHD_EMPTY;
            default:   state_d = SHD_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            SHD_ARMED: armed_o = 1'b1;
            default:   armed_o = 1'b0;
        endcase
        tag_o = tag_q;
    end

endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
    import pair_issue_pkg::*;
#(
    parameter  int REG_IDX_W = 5,
    localparam int TAG_W     = REG_IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_valid,
    input  logic [2:0]       l_cls,
    input  logic [TAG_W-1:0] l_dst,
    input  logic             l_dst_we,
    input  logic [TAG_W-1:0] l_src1,
    input  logic             l_src1_en,
    input  logic [TAG_W-1:0] l_src2,
    input  logic             l_src2_en,
    input  logic             r_valid,
    input  logic [2:0]       r_cls,
    input  logic [TAG_W-1:0] r_src1,
    input  logic             r_src1_en,
    input  logic [TAG_W-1:0] r_src2,
    input  logic             r_src2_en,
    output logic             issue_l,
    output logic             issue_r,
    output logic             fetch_hold,
    output logic             slide_r
);

    logic [2:0]       cls_arr  [NUM_SLOTS];
    slot_role_e       role_arr [NUM_SLOTS];

    logic             shd_armed;
    logic [TAG_W-1:0] shd_tag;
    logic             ld_capture;

    logic             l_hit_shd;
    logic             r_hit_shd;
    logic             r_hit_left;

    logic             left_int_side;
    logic             right_is_fp;
    logic             pair_ok;
    issue_dec_e       dec;

    assign cls_arr[SLOT_LEFT]  = l_cls;
    assign cls_arr[SLOT_RIGHT] = r_cls;

    // One class decoder per slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slot_decode u_dec (
            .cls_i  (cls_arr[s]),
            .role_o (role_arr[s])
        );
    end

    // Left sources against the in-flight load
    src_match #(.TAG_W(TAG_W)) u_left_vs_load (
        .src_a_i    (l_src1),
        .src_a_en_i (l_src1_en),
        .src_b_i    (l_src2),
        .src_b_en_i (l_src2_en),
        .prod_tag_i (shd_tag),
        .prod_en_i  (shd_armed),
        .hit_o      (l_hit_shd)
    );

    // Right sources against the in-flight load
    src_match #(.TAG_W(TAG_W)) u_right_vs_load (
        .src_a_i    (r_src1),
        .src_a_en_i (r_src1_en),
        .src_b_i    (r_src2),
        .src_b_en_i (r_src2_en),
        .prod_tag_i (shd_tag),
        .prod_en_i  (shd_armed),
        .hit_o      (r_hit_shd)
    );

    // Right sources against the partner's destination
    src_match #(.TAG_W(TAG_W)) u_right_vs_left (
        .src_a_i    (r_src1),
        .src_a_en_i (r_src1_en),
        .src_b_i    (r_src2),
        .src_b_en_i (r_src2_en),
        .prod_tag_i (l_dst),
        .prod_en_i  (l_dst_we),
        .hit_o      (r_hit_left)
    );

    load_shadow_fsm #(.TAG_W(TAG_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (ld_capture),
        .tag_i     (l_dst),
        .armed_o   (shd_armed),
        .tag_o     (shd_tag)
    );

    // Decision
    always_comb begin
        left_int_side = (role_arr[SLOT_LEFT] == ROLE_INT) ||
                        (role_arr[SLOT_LEFT] == ROLE_LOAD);
        right_is_fp   = (role_arr[SLOT_RIGHT] == ROLE_FP);
        pair_ok       = r_valid && left_int_side && right_is_fp &&
                        !r_hit_shd && !r_hit_left;
        if (!rst_n) begin
            dec = DEC_RESET;
        end else if (!l_valid) begin
            dec = DEC_EMPTY;
        end else if (l_hit_shd) begin
            dec = DEC_HOLD;
        end else if (pair_ok) begin
            dec = DEC_PAIR;
        end else begin
            dec = DEC_SINGLE;
        end
    end

    // Outputs from the decision
    always_comb begin
        issue_l    = 1'b0;
        issue_r    = 1'b0;
        fetch_hold = 1'b0;
        slide_r    = 1'b0;
        unique case (dec)
            DEC_RESET: begin
            end
            DEC_EMPTY: begin
                slide_r = r_valid;
            end
            DEC_HOLD: begin
                fetch_hold = 1'b1;
            end
            DEC_SINGLE: begin
                issue_l = 1'b1;
                slide_r = r_valid;
            end
            DEC_PAIR: begin
                issue_l = 1'b1;
                issue_r = 1'b1;
            end
            default: begin
            end
        endcase
        ld_capture = issue_l && (role_arr[SLOT_LEFT] == ROLE_LOAD) && l_dst_we;
    end

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
    parameter int TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             l_valid,
    input logic [2:0]       l_cls,
    input logic [TAG_W-1:0] l_dst,
    input logic             l_dst_we,
    input logic [TAG_W-1:0] l_src1,
    input logic             l_src1_en,
    input logic [TAG_W-1:0] l_src2,
    input logic             l_src2_en,
    input logic             r_valid,
    input logic [2:0]       r_cls,
    input logic [TAG_W-1:0] r_src1,
    input logic             r_src1_en,
    input logic [TAG_W-1:0] r_src2,
    input logic             r_src2_en,
    input logic             issue_l,
    input logic             issue_r,
    input logic             fetch_hold,
    input logic             slide_r
);

    logic             prev_ld;
    logic [TAG_W-1:0] prev_tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ld  <= 1'b0;
            prev_tag <= '0;
        end else begin
            prev_ld  <= issue_l && (l_cls == 3'd2) && l_dst_we;
            prev_tag <= l_dst;
        end
    end

    // R2
    left_waits_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ld && l_valid && ((l_src1_en && l_src1 == prev_tag) ||
                                (l_src2_en && l_src2 == prev_tag)))
        |-> (fetch_hold && !issue_l));

    // R3
    right_needs_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_r |-> issue_l);

    // R4
    pair_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_r |-> (r_cls == 3'd4 && l_cls <= 3'd3));

    // R5
    pair_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_r && l_dst_we) |->
        !((r_src1_en && r_src1 == l_dst) || (r_src2_en && r_src2 == l_dst)));

    // R6
    right_waits_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ld && ((r_src1_en && r_src1 == prev_tag) ||
                     (r_src2_en && r_src2 == prev_tag))) |-> !issue_r);

    // R7
    no_stale_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_ld && l_valid) |-> (issue_l && !fetch_hold));

    // R9
    hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold |-> (!issue_l && !issue_r && !slide_r));

    // R10
    slide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slide_r |-> (r_valid && !issue_r && !fetch_hold));

endmodule

bind pair_issue_ctl pair_issue_chk #(.TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .l_valid    (l_valid),
    .l_cls      (l_cls),
    .l_dst      (l_dst),
    .l_dst_we   (l_dst_we),
    .l_src1     (l_src1),
    .l_src1_en  (l_src1_en),
    .l_src2     (l_src2),
    .l_src2_en  (l_src2_en),
    .r_valid    (r_valid),
    .r_cls      (r_cls),
    .r_src1     (r_src1),
    .r_src1_en  (r_src1_en),
    .r_src2     (r_src2),
    .r_src2_en  (r_src2_en),
    .issue_l    (issue_l),
    .issue_r    (issue_r),
    .fetch_hold (fetch_hold),
    .slide_r    (slide_r)
);

// File: tb/pair_issue_ctl_tb.sv
module pair_issue_ctl_tb;

    typedef struct packed {
        logic       lv;
        logic [2:0] lc;
        logic [5:0] ld;
        logic       lwe;
        logic [5:0] la;
        logic       lae;
        logic [5:0] lb;
        logic       lbe;
        logic       rv;
        logic [2:0] rc;
        logic [5:0] ra;
        logic       rae;
        logic [5:0] rb;
        logic       rbe;
        logic [3:0] exp;   // {issue_l, issue_r, fetch_hold, slide_r}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;

    // Tags: integer rN = N, FP fN = 32 + N. Each row is one cycle; shadow carries over.
    localparam vec_t VEC [NV] = '{
        // 0 R1: nothing valid
        '{1'b0,3'd0,6'd0,1'b0,6'd0,1'b0,6'd0,1'b0, 1'b0,3'd0,6'd0,1'b0,6'd0,1'b0, 4'b0000, 4'd1},
        // 1 R4: ALU r1<=r2,r3 with FP f0,f2 -> pair
        '{1'b1,3'd0,6'd1,1'b1,6'd2,1'b1,6'd3,1'b1, 1'b1,3'd4,6'd32,1'b1,6'd34,1'b1, 4'b1100, 4'd4},
        // 2 R5: load f0, right reads f0 -> single, slide
        '{1'b1,3'd2,6'd32,1'b1,6'd1,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd32,1'b1,6'd34,1'b1, 4'b1001, 4'd5},
        // 3 R2: left FP reads f0 one cycle after load -> hold
        '{1'b1,3'd4,6'd36,1'b1,6'd32,1'b1,6'd34,1'b1, 1'b1,3'd4,6'd38,1'b1,6'd40,1'b1, 4'b0010, 4'd2},
        // 4 R9: same pair again, load gone; FP in left -> single
        '{1'b1,3'd4,6'd36,1'b1,6'd32,1'b1,6'd34,1'b1, 1'b1,3'd4,6'd38,1'b1,6'd40,1'b1, 4'b1001, 4'd9},
        // 5 R8: FP load f6 with independent FP op -> pair
        '{1'b1,3'd2,6'd38,1'b1,6'd1,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd42,1'b1,6'd44,1'b1, 4'b1100, 4'd8},
        // 6 R6: right reads f6 of previous load -> single
        '{1'b1,3'd0,6'd2,1'b1,6'd3,1'b1,6'd4,1'b1, 1'b1,3'd4,6'd38,1'b1,6'd34,1'b1, 4'b1001, 4'd6},
        // 7 R7 setup: load r9 with FP op -> pair
        '{1'b1,3'd2,6'd9,1'b1,6'd1,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd36,1'b1,6'd38,1'b1, 4'b1100, 4'd7},
        // 8 R2: f9 is not r9 -> pair
        '{1'b1,3'd3,6'd0,1'b0,6'd41,1'b1,6'd1,1'b1, 1'b1,3'd4,6'd41,1'b1,6'd42,1'b1, 4'b1100, 4'd2},
        // 9 R7: reads r9 two pairs after load -> pair
        '{1'b1,3'd0,6'd3,1'b1,6'd9,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd32,1'b1,6'd34,1'b1, 4'b1100, 4'd7},
        // 10 R8: load r7 -> pair
        '{1'b1,3'd2,6'd7,1'b1,6'd1,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd40,1'b1,6'd42,1'b1, 4'b1100, 4'd8},
        // 11 R9: load r8 reads r7 -> hold
        '{1'b1,3'd2,6'd8,1'b1,6'd7,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd40,1'b1,6'd42,1'b1, 4'b0010, 4'd9},
        // 12 R11: held load r8 must not block a reader of r8
        '{1'b1,3'd0,6'd10,1'b1,6'd8,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd40,1'b1,6'd42,1'b1, 4'b1100, 4'd11},
        // 13 R10: right empty -> left alone, no slide
        '{1'b1,3'd0,6'd11,1'b1,6'd1,1'b1,6'd2,1'b1, 1'b0,3'd4,6'd40,1'b1,6'd42,1'b1, 4'b1000, 4'd10},
        // 14 R3: left empty, right valid -> nothing issues, slide
        '{1'b0,3'd0,6'd0,1'b0,6'd0,1'b0,6'd0,1'b0, 1'b1,3'd4,6'd40,1'b1,6'd42,1'b1, 4'b0001, 4'd3},
        // 15 R4: branch with class-5 right -> single
        '{1'b1,3'd1,6'd0,1'b0,6'd1,1'b1,6'd0,1'b0, 1'b1,3'd5,6'd40,1'b1,6'd42,1'b1, 4'b1001, 4'd4},
        // 16 R5: store, dst field f4 but no write -> pair
        '{1'b1,3'd3,6'd36,1'b0,6'd1,1'b1,6'd35,1'b1, 1'b1,3'd4,6'd36,1'b1,6'd40,1'b0, 4'b1100, 4'd5},
        // 17 R5: load f1, right reads f1 on second source -> single
        '{1'b1,3'd2,6'd33,1'b1,6'd1,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd32,1'b1,6'd33,1'b1, 4'b1001, 4'd5},
        // 18 R6: right names f1 on a disabled source -> pair
        '{1'b1,3'd0,6'd4,1'b1,6'd5,1'b1,6'd6,1'b1, 1'b1,3'd4,6'd33,1'b0,6'd34,1'b1, 4'b1100, 4'd6},
        // 19 R7: reads f1 two pairs after load -> pair
        '{1'b1,3'd0,6'd12,1'b1,6'd33,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd40,1'b1,6'd42,1'b1, 4'b1100, 4'd7},
        // 20 R11 setup: load r5 without write -> pair
        '{1'b1,3'd2,6'd5,1'b0,6'd1,1'b1,6'd0,1'b0, 1'b1,3'd4,6'd40,1'b1,6'd42,1'b1, 4'b1100, 4'd11},
        // 21 R11: reader of r5 is not held
        '{1'b1,3'd0,6'd13,1'b1,6'd5,1'b1,6'd5,1'b1, 1'b1,3'd4,6'd5,1'b1,6'd42,1'b1, 4'b1100, 4'd11}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       l_valid, l_dst_we, l_src1_en, l_src2_en;
    logic [2:0] l_cls, r_cls;
    logic [5:0] l_dst, l_src1, l_src2, r_src1, r_src2;
    logic       r_valid, r_src1_en, r_src2_en;
    logic       issue_l, issue_r, fetch_hold, slide_r;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pair_issue_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .l_valid    (l_valid),
        .l_cls      (l_cls),
        .l_dst      (l_dst),
        .l_dst_we   (l_dst_we),
        .l_src1     (l_src1),
        .l_src1_en  (l_src1_en),
        .l_src2     (l_src2),
        .l_src2_en  (l_src2_en),
        .r_valid    (r_valid),
        .r_cls      (r_cls),
        .r_src1     (r_src1),
        .r_src1_en  (r_src1_en),
        .r_src2     (r_src2),
        .r_src2_en  (r_src2_en),
        .issue_l    (issue_l),
        .issue_r    (issue_r),
        .fetch_hold (fetch_hold),
        .slide_r    (slide_r)
    );

    task automatic drive(input vec_t v);
        l_valid = v.lv;  l_cls = v.lc;  l_dst = v.ld;  l_dst_we = v.lwe;
        l_src1 = v.la;   l_src1_en = v.lae;
        l_src2 = v.lb;   l_src2_en = v.lbe;
        r_valid = v.rv;  r_cls = v.rc;
        r_src1 = v.ra;   r_src1_en = v.rae;
        r_src2 = v.rb;   r_src2_en = v.rbe;
    endtask

    task automatic check(input logic [3:0] exp, input string req);
        logic [3:0] got;
        got = {issue_l, issue_r, fetch_hold, slide_r};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        vec_t v;
        rst_n = 1'b0;
        drive(VEC[1]);
        repeat (2) @(negedge clk);
        #1 check(4'b0000, "R1 outputs in reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1 check(VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R1: reset while a load is in flight clears the delay
        v = VEC[0];
        v.lv = 1'b1; v.lc = 3'd2; v.ld = 6'd13; v.lwe = 1'b1; v.la = 6'd1; v.lae = 1'b1;
        @(negedge clk);
        drive(v);
        #1 check(4'b1000, "R1 load before reset");
        v.lc = 3'd0; v.ld = 6'd14; v.la = 6'd13;
        @(negedge clk);
        rst_n = 1'b0;
        drive(v);
        #1 check(4'b0000, "R1 consumer in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(4'b1000, "R1 shadow cleared by reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule